// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Signal Generator

This block holds the hypervisor's control word for a virtual interrupt CPU interface and derives a level-sensitive maintenance interrupt from it. Software writes the word through a simple write-enable port and reads it back at any time. The word carries a global interface enable, eight bits that select which conditions raise the interrupt, a muting control for virtual SGI deactivations, six trap and mask controls, and a small counter of end-of-interrupt events.

The counter advances whenever the interface reports a deactivation for which no valid list entry exists. This lets the hypervisor notice deactivations it must finish in software. A nonzero counter can itself raise the maintenance interrupt. The other conditions come from the list-entry valid bits, the pending state of each entry, and the two virtual group enables. The interrupt output is registered.

Top module: `vint_maint_gen`

## Requirements
- R1: The read value always shows zero in bits 63:32, bits 26:16 and bit 9.
- R2: After reset every field reads zero and the maintenance interrupt is low.
- R3: A write loads bits 31:27 (count), 15:10 (trap controls), 8 (SGI mute) and 7:0 (interrupt controls) from the write data. The read value shows them from the cycle after the write.
- R4: While bit 0 (global enable) is clear, the maintenance interrupt stays low whatever the other bits hold.
- R5: The count in bits 31:27 goes up by one on a deactivation strobe that flags no matching list entry. A deactivation that has a matching entry leaves it unchanged.
- R6: While bit 8 is set, a deactivation flagged as a virtual SGI does not change the count. While bit 8 is clear, such a deactivation counts like any other.
- R7: The count goes from 31 to 0 on increment. A write in the same cycle as a counting deactivation wins, and the written value is stored.
- R8: With bits 0 and 2 set, the interrupt is high while the count is nonzero.
- R9: With bits 0 and 1 set, the interrupt is high while at most one list entry has its valid bit set.
- R10: With bits 0 and 3 set, the interrupt is high while no list entry has state code 2'b01 (pending). Other state codes do not count as pending.
- R11: With bit 0 set, the interrupt is high when bit 4 is set and the group 0 enable is 1, or bit 5 is set and it is 0. It is also high when bit 6 is set and the group 1 enable is 1, or bit 7 is set and it is 0.
- R12: Bits 10 to 15 are stored and read back but never affect the interrupt.
- R13: The interrupt is registered. It reflects the register contents and inputs of the previous cycle and does not change before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Current control word |
| lrValid | input | NUM_LR | Valid bit of each list entry |
| lrState | input | 2*NUM_LR | Two-bit state of each list entry, entry i at bits 2i+1:2i |
| grp0En | input | 1 | Virtual group 0 enable |
| grp1En | input | 1 | Virtual group 1 enable |
| deactStb | input | 1 | Deactivation event strobe |
| deactNoEntry | input | 1 | Event has no matching valid list entry |
| deactIsSgi | input | 1 | Event concerns a virtual SGI |
| maintIrq | output | 1 | Maintenance interrupt, level |

## Verification
The bench builds the block with four list entries. With four entries, the underflow boundary between one and two valid entries can be reached, and a single entry can be marked pending while the others hold other state codes. The count width is fixed by its field, so the wrap from 31 to 0 is reached by preloading 31 through a write and issuing one counting deactivation. The same-cycle collision of a write and a counting deactivation is also driven.

// File: rtl/vint_maint_pkg.sv
`timescale 1ns/1ps
package vint_maint_pkg;

  localparam int CTRL_W     = 64;
  localparam int CNT_W      = 5;
  localparam int CNT_LO     = 27;
  localparam int CNT_HI     = CNT_LO + CNT_W - 1;
  localparam int TRAP_W     = 6;
  localparam int TRAP_LO    = 10;
  localparam int SGI_MUTE   = 8;
  localparam int IRQ_CFG_W  = 8;

  localparam logic [1:0] LR_PENDING = 2'b01;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  localparam logic [CTRL_W-1:0] WR_MASK =
      ((CTRL_W'(1) << CNT_W) - CTRL_W'(1)) << CNT_LO |
      ((CTRL_W'(1) << TRAP_W) - CTRL_W'(1)) << TRAP_LO |
      (CTRL_W'(1) << SGI_MUTE) |
      ((CTRL_W'(1) << IRQ_CFG_W) - CTRL_W'(1));

  typedef struct packed {
    logic loadWord;
    logic bumpCount;
  } ctrlStrobe_t;

  typedef struct packed {
    logic grp1DisIe;
    logic grp1EnIe;
    logic grp0DisIe;
    logic grp0EnIe;
    logic noPendIe;
    logic lrenpIe;
    logic underIe;
    logic globalEn;
  } irqCfg_t;

endpackage

// File: rtl/vint_ctrl.sv
`timescale 1ns/1ps
module vint_ctrl
  import vint_maint_pkg::*;
(
  input  logic        wrEn,
  input  logic        deactStb,
  input  logic        deactNoEntry,
  input  logic        deactIsSgi,
  input  logic        sgiMute,
  output ctrlStrobe_t strobe
);

  logic deactCounts;

  // An orphan deactivation counts unless it is a muted virtual SGI.
  always_comb begin
    deactCounts      = deactStb & deactNoEntry & ~(deactIsSgi & sgiMute);
    strobe.loadWord  = wrEn;
    strobe.bumpCount = deactCounts & ~wrEn;
  end

endmodule

// File: rtl/vint_regs.sv
`timescale 1ns/1ps
module vint_regs
  import vint_maint_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] rdData,
  output irqCfg_t           irqCfg,
  output logic [CNT_W-1:0]  eoiCount,
  output logic              sgiMute
);

  logic [CTRL_W-1:0] ctrlQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (strobe.loadWord) begin
      ctrlQ <= wrData & WR_MASK;
    end else if (strobe.bumpCount) begin
      ctrlQ[CNT_HI:CNT_LO] <= ctrlQ[CNT_HI:CNT_LO] + CNT_ONE;
    end
  end

  always_comb begin
    rdData   = ctrlQ;
    irqCfg   = irqCfg_t'(ctrlQ[IRQ_CFG_W-1:0]);
    eoiCount = ctrlQ[CNT_HI:CNT_LO];
    sgiMute  = ctrlQ[SGI_MUTE];
  end

endmodule

// File: rtl/vint_cond.sv
`timescale 1ns/1ps
module vint_cond
  import vint_maint_pkg::*;
#(
  parameter int NUM_LR = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  irqCfg_t             irqCfg,
  input  logic [CNT_W-1:0]    eoiCount,
  input  logic [NUM_LR-1:0]   lrValid,
  input  logic [2*NUM_LR-1:0] lrState,
  input  logic                grp0En,
  input  logic                grp1En,
  output logic                maintIrq
);

  localparam int VCNT_W = $clog2(NUM_LR + 1);

  logic [NUM_LR-1:0] pendVec;
  logic [VCNT_W-1:0] validCnt;
  logic              underflow;
  logic              noPend;
  logic              condHit;
  logic              irqD;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_pend
    assign pendVec[i] = (lrState[2*i +: 2] == LR_PENDING);
  end

  always_comb begin
    validCnt = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      validCnt = validCnt + VCNT_W'(lrValid[i]);
    end
  end

  always_comb begin
    underflow = (validCnt <= VCNT_W'(1));
    noPend    = ~|pendVec;
    condHit   = (irqCfg.underIe   & underflow)
              | (irqCfg.lrenpIe   & (|eoiCount))
              | (irqCfg.noPendIe  & noPend)
              | (irqCfg.grp0EnIe  & grp0En)
              | (irqCfg.grp0DisIe & ~grp0En)
              | (irqCfg.grp1EnIe  & grp1En)
              | (irqCfg.grp1DisIe & ~grp1En);
    irqD      = irqCfg.globalEn & condHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) maintIrq <= 1'b0;
    else       maintIrq <= irqD;
  end

endmodule

// File: rtl/vint_maint_gen.sv
`timescale 1ns/1ps
module vint_maint_gen
  import vint_maint_pkg::*;
#(
  parameter int NUM_LR = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [63:0]         wrData,
  output logic [63:0]         rdData,
  input  logic [NUM_LR-1:0]   lrValid,
  input  logic [2*NUM_LR-1:0] lrState,
  input  logic                grp0En,
  input  logic                grp1En,
  input  logic                deactStb,
  input  logic                deactNoEntry,
  input  logic                deactIsSgi,
  output logic                maintIrq
);

  ctrlStrobe_t        strobe;
  irqCfg_t            irqCfg;
  logic [CNT_W-1:0]   eoiCount;
  logic               sgiMute;

  vint_ctrl u_ctrl (
    .wrEn         (wrEn),
    .deactStb     (deactStb),
    .deactNoEntry (deactNoEntry),
    .deactIsSgi   (deactIsSgi),
    .sgiMute      (sgiMute),
    .strobe       (strobe)
  );

  vint_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdData   (rdData),
    .irqCfg   (irqCfg),
    .eoiCount (eoiCount),
    .sgiMute  (sgiMute)
  );

  vint_cond #(.NUM_LR(NUM_LR)) u_cond (
    .clk      (clk),
    .rstN     (rstN),
    .irqCfg   (irqCfg),
    .eoiCount (eoiCount),
    .lrValid  (lrValid),
    .lrState  (lrState),
    .grp0En   (grp0En),
    .grp1En   (grp1En),
    .maintIrq (maintIrq)
  );

endmodule

// File: rtl/vint_maint_chk.sv
`timescale 1ns/1ps
module vint_maint_chk
  import vint_maint_pkg::*;
#(
  parameter int NUM_LR = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [63:0]       wrData,
  input logic [63:0]       rdData,
  input logic [NUM_LR-1:0] lrValid,
  input logic              deactStb,
  input logic              deactIsSgi,
  input logic              maintIrq
);

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[63:32] == '0) && (rdData[26:16] == '0) && !rdData[9]);

  // R3
  write_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == ($past(wrData) & WR_MASK)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !deactStb) |=> $stable(rdData));

  // R6
  sgi_mute_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && deactStb && deactIsSgi && rdData[SGI_MUTE]) |=> $stable(rdData));

  // R4
  global_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[0] |=> !maintIrq);

  // R9
  underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[0] && rdData[1] && ($countones(lrValid) <= 1)) |=> maintIrq);

  // R8
  count_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[0] && rdData[2] && (rdData[CNT_HI:CNT_LO] != '0)) |=> maintIrq);

endmodule

bind vint_maint_gen vint_maint_chk #(.NUM_LR(NUM_LR)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .lrValid    (lrValid),
  .deactStb   (deactStb),
  .deactIsSgi (deactIsSgi),
  .maintIrq   (maintIrq)
);

// File: tb/test_vint_maint_gen.sv
`timescale 1ns/1ps
module test_vint_maint_gen;

  localparam int NUM_LR = 4;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                wrEn = 1'b0;
  logic [63:0]         wrData = '0;
  logic [63:0]         rdData;
  logic [NUM_LR-1:0]   lrValid = '0;
  logic [2*NUM_LR-1:0] lrState = '0;
  logic                grp0En = 1'b0;
  logic                grp1En = 1'b0;
  logic                deactStb = 1'b0;
  logic                deactNoEntry = 1'b0;
  logic                deactIsSgi = 1'b0;
  logic                maintIrq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [63:0] expRdQ[$];
  logic        expIrqQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  vint_maint_gen #(.NUM_LR(NUM_LR)) i_vint_maint_gen (
    .clk, .rstN, .wrEn, .wrData, .rdData, .lrValid, .lrState,
    .grp0En, .grp1En, .deactStb, .deactNoEntry, .deactIsSgi, .maintIrq
  );

  // Monitor: compare queued expectations at the falling edge.
  always @(negedge clk) begin
    while (expRdQ.size() > 0) begin
      logic [63:0] eRd;
      logic        eIrq;
      string       tg;
      eRd  = expRdQ.pop_front();
      eIrq = expIrqQ.pop_front();
      tg   = tagQ.pop_front();
      testsRun++;
      if (rdData !== eRd || maintIrq !== eIrq) begin
        testsFailed++;
        $display("FAIL %s: rdData=%h maintIrq=%b expected rdData=%h maintIrq=%b",
                 tg, rdData, maintIrq, eRd, eIrq);
      end
    end
  end

  task automatic expectNow(input logic [63:0] r, input logic q, input string tg);
    expRdQ.push_back(r);
    expIrqQ.push_back(q);
    tagQ.push_back(tg);
    @(negedge clk);
    #1;
  endtask

  task automatic wrReg(input logic [63:0] v);
    wrEn = 1'b1;
    wrData = v;
    @(posedge clk); #1;
    wrEn = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic setLr(input logic [NUM_LR-1:0] v, input logic [2*NUM_LR-1:0] s);
    lrValid = v;
    lrState = s;
    @(posedge clk); #1;
  endtask

  task automatic setGrp(input logic g0, input logic g1);
    grp0En = g0;
    grp1En = g1;
    @(posedge clk); #1;
  endtask

  task automatic deact(input logic noEntry, input logic isSgi);
    deactStb = 1'b1;
    deactNoEntry = noEntry;
    deactIsSgi = isSgi;
    @(posedge clk); #1;
    deactStb = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    expectNow(64'h0, 1'b0, "R2 reset");

    // R1 R3: reserved bits drop, count 31 and all enables set
    wrReg('1);
    expectNow(64'h0000_0000_F800_FDFF, 1'b1, "R1 R3 all-ones write");

    // R4: every condition enabled but global enable clear
    wrReg(64'hFFFF_FFFF_0000_00FE);
    expectNow(64'h0000_0000_0000_00FE, 1'b0, "R4 global enable off");

    // R9 underflow boundary
    wrReg(64'h3);
    expectNow(64'h3, 1'b1, "R9 zero valid");
    setLr(4'b0001, 8'h00);
    expectNow(64'h3, 1'b1, "R9 one valid");
    setLr(4'b0011, 8'h00);
    expectNow(64'h3, 1'b0, "R9 two valid");

    // R10 pending state code 01 on entry 2
    wrReg(64'h9);
    expectNow(64'h9, 1'b1, "R10 no pending");
    setLr(4'b1111, 8'b00_01_00_00);
    expectNow(64'h9, 1'b0, "R10 entry pending");
    setLr(4'b1111, 8'b00_10_00_00);
    expectNow(64'h9, 1'b1, "R10 state 10 not pending");

    // R11 group enables
    setGrp(1'b1, 1'b0);
    wrReg(64'h11);
    expectNow(64'h11, 1'b1, "R11 grp0 enabled");
    setGrp(1'b0, 1'b0);
    expectNow(64'h11, 1'b0, "R11 grp0 off no hit");
    wrReg(64'h21);
    expectNow(64'h21, 1'b1, "R11 grp0 disabled");
    setGrp(1'b0, 1'b1);
    wrReg(64'h41);
    expectNow(64'h41, 1'b1, "R11 grp1 enabled");
    wrReg(64'h81);
    expectNow(64'h81, 1'b0, "R11 grp1 on no hit");
    setGrp(1'b0, 1'b0);
    expectNow(64'h81, 1'b1, "R11 grp1 disabled");

    // R12 trap bits stored, no effect
    wrReg(64'hFC01);
    expectNow(64'hFC01, 1'b0, "R12 trap bits inert");

    // R5 R6 R8 counting
    wrReg(64'h5);
    expectNow(64'h5, 1'b0, "R8 count zero");
    deact(1'b1, 1'b0);
    expectNow(64'h0800_0005, 1'b1, "R5 R8 orphan deactivation");
    deact(1'b0, 1'b0);
    expectNow(64'h0800_0005, 1'b1, "R5 matched deactivation ignored");
    deact(1'b1, 1'b1);
    expectNow(64'h1000_0005, 1'b1, "R6 sgi counts when unmuted");
    wrReg(64'h1000_0105);
    expectNow(64'h1000_0105, 1'b1, "R6 mute set");
    deact(1'b1, 1'b1);
    expectNow(64'h1000_0105, 1'b1, "R6 muted sgi ignored");
    deact(1'b1, 1'b0);
    expectNow(64'h1800_0105, 1'b1, "R6 non-sgi still counts");

    // R7 wrap and write priority
    wrReg(64'hF800_0005);
    expectNow(64'hF800_0005, 1'b1, "R7 preload 31");
    deact(1'b1, 1'b0);
    expectNow(64'h5, 1'b0, "R7 wrap to zero");
    wrEn = 1'b1;
    wrData = 64'h1000_0005;
    deactStb = 1'b1;
    deactNoEntry = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
    deactStb = 1'b0;
    @(posedge clk); #1;
    expectNow(64'h1000_0005, 1'b1, "R7 write beats increment");

    // R13 one-cycle latency
    wrReg(64'h3);
    expectNow(64'h3, 1'b0, "R13 baseline four valid");
    @(posedge clk); #1;
    lrValid = 4'b0000;
    expectNow(64'h3, 1'b0, "R13 no change before edge");
    @(posedge clk); #1;
    expectNow(64'h3, 1'b1, "R13 change after edge");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule